// File: doc/BRIEF.md
# Audio Sample FIFO Controller

This block buffers the sample words of a serial audio port in two first-in first-out stores: one for transmit (filled by the host or DMA side, drained by the serial shifter) and one for receive (filled by the shifter, drained by the host). Each store holds 32 words of 16 bits. Each store reports its live fill count and four level flags. Each store also raises a DMA request when its fill level crosses a programmable threshold: for transmit the level must be at or below the threshold, and for receive at or above it.

Conditions in both directions are latched into a 13-bit sticky status word. These conditions are the level flags, starve (a word was taken from an empty store) and overflow (a word was offered to a full store), plus one word-transferred event. The status word is cleared by a write-one-to-clear mask. Each status bit has its own enable, and a global enable gates the OR of the enabled bits onto a single interrupt line.

Each direction is sequenced by a two-state machine. FIFO_OFF is the reset state: the store is empty, and pushes and pops are ignored. The transition OFF-to-RUN fires on the first clock on which that direction's FIFO enable is high. FIFO_RUN is the working state. The transition RUN-to-OFF fires when the enable is low at a clock edge, and it flushes the store on that same edge.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: After reset both counts are 0, the level flags read 4'b0011, the status word and `irq` are 0, and both DMA requests are 0.
- R2: Each store keeps words in first-in first-out order with a depth of 32. The count rises by one per accepted push and falls by one per accepted pop. The transmit head is presented on `tx_sdata` while the store is non-empty.
- R3: A push into a full store is dropped, and the count stays 32. It sets the overflow status bit: bit 5 for a host write to transmit, bit 11 for a shifter push to receive.
- R4: A pop from an empty store sets the starve status bit: bit 4 for a shifter request on transmit (`tx_sdata` reads 0 in that cycle), bit 10 for a host read on receive.
- R5: `tx_dma_req` is 1 exactly when `tx_dma_en` is 1, transmit is in FIFO_RUN, and `tx_count` <= `tx_thresh`.
- R6: `rx_dma_req` is 1 exactly when `rx_dma_en` is 1, receive is in FIFO_RUN, and `rx_count` >= `rx_thresh`.
- R7: Level flags are laid out as bit 0 empty (count 0), bit 1 almost-empty (count <= 4), bit 2 almost-full (count >= 28), and bit 3 full (count 32).
- R8: The status layout is transmit at base 0 and receive at base 6. At each base, offset 0 is empty, 1 almost-empty, 2 almost-full, 3 full, 4 starve and 5 overflow. Level conditions latch only while the direction is running. A status bit stays 1 until a cycle with its `clr_mask` bit set. A set condition in the same cycle wins over the clear.
- R9: `irq` equals `irq_global_en` AND the OR of (`irq_status` AND `irq_src_en`).
- R10: A low FIFO enable at a clock edge empties that store, and while the enable is low, pushes and pops have no effect and latch no status.
- R11: Status bit 12 latches whenever any word is accepted into or out of either store.
- R12: `rx_rdata[16]` is 1 only when the receive store holds a word, and `rx_rdata[15:0]` is then its head word. Otherwise the whole of `rx_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_fifo_en | input | 1 | Transmit store enable |
| rx_fifo_en | input | 1 | Receive store enable |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_thresh | input | 6 | Transmit request threshold |
| rx_thresh | input | 6 | Receive request threshold |
| tx_wr | input | 1 | Host pushes `tx_wdata` into transmit |
| tx_wdata | input | 16 | Host transmit word |
| tx_req_word | input | 1 | Shifter takes the transmit head |
| tx_sdata | output | 16 | Transmit head to shifter, 0 when empty |
| rx_push | input | 1 | Shifter pushes `rx_sdata` into receive |
| rx_sdata | input | 16 | Shifter receive word |
| rx_rd | input | 1 | Host pops the receive head |
| rx_rdata | output | 17 | Valid bit 16 and receive head word |
| tx_count | output | 6 | Transmit fill count |
| rx_count | output | 6 | Receive fill count |
| tx_flags | output | 4 | Transmit level flags |
| rx_flags | output | 4 | Receive level flags |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq_src_en | input | 13 | Per-status-bit interrupt enables |
| irq_global_en | input | 1 | Global interrupt enable |
| clr_mask | input | 13 | Write-one-to-clear mask for the status word |
| irq_status | output | 13 | Sticky status word |
| irq | output | 1 | Interrupt line |

## Verification
A table drives both stores to ten fill levels against ten thresholds: empty, the almost-empty edge at 4 and 5, the almost-full edge at 27 and 28, and full. At each level the bench compares both DMA requests and the level flags, so an off-by-one in either comparison direction is exposed. Directed patterns then fill past full, pop from empty, and clear status bits while their condition is absent or still present. Other patterns toggle the interrupt enables and drop a direction's enable with data inside. Together these separate a dropped word from an overwritten one, a sticky bit from a live one, and a clear that loses to a set from one that wins.

// File: rtl/afq_pkg.sv
package afq_pkg;
    localparam int SRC_PER_DIR = 6;
    localparam int NUM_SRC     = 2 * SRC_PER_DIR + 1;
    localparam int XFER_BIT    = 2 * SRC_PER_DIR;

    typedef enum logic {
        FIFO_OFF = 1'b0,
        FIFO_RUN = 1'b1
    } fifo_state_e;
endpackage

// File: rtl/afq_fifo.sv
module afq_fifo
    import afq_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DEPTH  = 32,
    parameter int AE_LVL = 4,
    parameter int AF_LVL = 28,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic [3:0]    lvl,
    output logic          running,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          ovf_evt,
    output logic          starve_evt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fifo_state_e state_q, state_d;
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          empty, full;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FIFO_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FIFO_OFF: if (en)  state_d = FIFO_RUN;
            FIFO_RUN: if (!en) state_d = FIFO_OFF;
            default:           state_d = FIFO_OFF;
        endcase
    end

    // outputs
    always_comb begin
        running    = (state_q == FIFO_RUN);
        empty      = (count == '0);
        full       = (count == CW'(DEPTH));
        lvl[0]     = empty;
        lvl[1]     = (count <= CW'(AE_LVL));
        lvl[2]     = (count >= CW'(AF_LVL));
        lvl[3]     = full;
        push_ok    = running && en && push && !full;
        pop_ok     = running && en && pop && !empty;
        ovf_evt    = running && en && push && full;
        starve_evt = running && en && pop && empty;
        head       = mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (running && !en) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= ptr_inc(wptr);
            if (pop_ok)  rptr <= ptr_inc(rptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end
endmodule

// File: rtl/afq_status.sv
module afq_status
    import afq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] src_en,
    input  logic         global_en,
    output logic [N-1:0] status,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | set_vec;
    end

    always_comb irq = global_en && (|(status & src_en));
endmodule

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl
    import afq_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DEPTH  = 32,
    parameter int AE_LVL = 4,
    parameter int AF_LVL = 28,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_fifo_en,
    input  logic               rx_fifo_en,
    input  logic               tx_dma_en,
    input  logic               rx_dma_en,
    input  logic [CW-1:0]      tx_thresh,
    input  logic [CW-1:0]      rx_thresh,
    input  logic               tx_wr,
    input  logic [DW-1:0]      tx_wdata,
    input  logic               tx_req_word,
    output logic [DW-1:0]      tx_sdata,
    input  logic               rx_push,
    input  logic [DW-1:0]      rx_sdata,
    input  logic               rx_rd,
    output logic [DW:0]        rx_rdata,
    output logic [CW-1:0]      tx_count,
    output logic [CW-1:0]      rx_count,
    output logic [3:0]         tx_flags,
    output logic [3:0]         rx_flags,
    output logic               tx_dma_req,
    output logic               rx_dma_req,
    input  logic [NUM_SRC-1:0] irq_src_en,
    input  logic               irq_global_en,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] irq_status,
    output logic               irq
);
    logic [1:0]    en_a, push_a, pop_a;
    logic [1:0]    run_a, pok_a, qok_a, ovf_a, stv_a;
    logic [DW-1:0] pdata_a [2];
    logic [DW-1:0] head_a  [2];
    logic [CW-1:0] cnt_a   [2];
    logic [3:0]    lvl_a   [2];
    logic [NUM_SRC-1:0] set_vec;

    // index 0 = transmit, index 1 = receive
    assign en_a       = {rx_fifo_en, tx_fifo_en};
    assign push_a     = {rx_push, tx_wr};
    assign pop_a      = {rx_rd, tx_req_word};
    assign pdata_a[0] = tx_wdata;
    assign pdata_a[1] = rx_sdata;

    for (genvar d = 0; d < 2; d++) begin : g_dir
        afq_fifo #(
            .DW(DW), .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL)
        ) u_fifo (
            .clk(clk), .rst_n(rst_n), .en(en_a[d]),
            .push(push_a[d]), .push_data(pdata_a[d]), .pop(pop_a[d]),
            .head(head_a[d]), .count(cnt_a[d]), .lvl(lvl_a[d]),
            .running(run_a[d]), .push_ok(pok_a[d]), .pop_ok(qok_a[d]),
            .ovf_evt(ovf_a[d]), .starve_evt(stv_a[d])
        );
        assign set_vec[d*SRC_PER_DIR +: SRC_PER_DIR] =
            {ovf_a[d], stv_a[d], lvl_a[d] & {4{run_a[d]}}};
    end

    assign set_vec[XFER_BIT] = (|pok_a) | (|qok_a);

    afq_status #(.N(NUM_SRC)) u_status (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_mask(clr_mask),
        .src_en(irq_src_en), .global_en(irq_global_en),
        .status(irq_status), .irq(irq)
    );

    always_comb begin
        tx_count   = cnt_a[0];
        rx_count   = cnt_a[1];
        tx_flags   = lvl_a[0];
        rx_flags   = lvl_a[1];
        tx_sdata   = lvl_a[0][0] ? '0 : head_a[0];
        rx_rdata   = lvl_a[1][0] ? '0 : {1'b1, head_a[1]};
        tx_dma_req = tx_dma_en && run_a[0] && (cnt_a[0] <= tx_thresh);
        rx_dma_req = rx_dma_en && run_a[1] && (cnt_a[1] >= rx_thresh);
    end
endmodule

// File: rtl/audio_fifo_ctrl_chk.sv
module audio_fifo_ctrl_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = 6,
    parameter int DW    = 16,
    parameter int NS    = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_fifo_en,
    input logic          rx_fifo_en,
    input logic [CW-1:0] tx_thresh,
    input logic          tx_req_word,
    input logic [DW-1:0] tx_sdata,
    input logic          rx_push,
    input logic          rx_rd,
    input logic [DW:0]   rx_rdata,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          tx_dma_req,
    input logic [NS-1:0] irq_src_en,
    input logic          irq_global_en,
    input logic [NS-1:0] clr_mask,
    input logic [NS-1:0] irq_status,
    input logic          irq
);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fifo_en && rx_push && !rx_rd && rx_count == CW'(DEPTH))
        |=> (rx_count == CW'(DEPTH) && irq_status[11]));

    assert_starve_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_word && tx_count == '0) |-> (tx_sdata == '0));

    assert_tx_req_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> (tx_count <= tx_thresh));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_status & $past(irq_status & ~clr_mask))
                  == $past(irq_status & ~clr_mask)));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_global_en || (irq_status & irq_src_en) == '0) |-> !irq);

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_fifo_en |=> (tx_count == '0));

    assert_rx_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !rx_rdata[DW]);
endmodule

bind audio_fifo_ctrl audio_fifo_ctrl_chk #(
    .DEPTH(DEPTH), .CW(CW), .DW(DW), .NS(afq_pkg::NUM_SRC)
) u_chk (.*);

// File: tb/audio_fifo_ctrl_test.sv
`timescale 1ns/100ps
module audio_fifo_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_fifo_en = 0, rx_fifo_en = 0, tx_dma_en = 0, rx_dma_en = 0;
    logic [5:0]  tx_thresh = 6'd4, rx_thresh = 6'd32;
    logic        tx_wr = 0, tx_req_word = 0, rx_push = 0, rx_rd = 0;
    logic [15:0] tx_wdata = '0, rx_sdata = '0;
    logic [15:0] tx_sdata;
    logic [16:0] rx_rdata;
    logic [5:0]  tx_count, rx_count;
    logic [3:0]  tx_flags, rx_flags;
    logic        tx_dma_req, rx_dma_req;
    logic [12:0] irq_src_en = '0, clr_mask = '0, irq_status;
    logic        irq_global_en = 0, irq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    audio_fifo_ctrl uut (.*);

    // fill[17:12] thr[11:6] exp_tx[5] exp_rx[4] flags[3:0]
    localparam logic [17:0] VEC [10] = '{
        {6'd0,  6'd4,  1'b1, 1'b0, 4'b0011},
        {6'd4,  6'd4,  1'b1, 1'b1, 4'b0010},
        {6'd5,  6'd4,  1'b0, 1'b1, 4'b0000},
        {6'd3,  6'd4,  1'b1, 1'b0, 4'b0010},
        {6'd32, 6'd32, 1'b1, 1'b1, 4'b1100},
        {6'd31, 6'd32, 1'b1, 1'b0, 4'b0100},
        {6'd20, 6'd0,  1'b0, 1'b1, 4'b0000},
        {6'd0,  6'd0,  1'b1, 1'b1, 4'b0011},
        {6'd28, 6'd28, 1'b1, 1'b1, 4'b0100},
        {6'd27, 6'd30, 1'b1, 1'b0, 4'b0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic restart();
        tx_fifo_en = 0; rx_fifo_en = 0; cyc();
        tx_fifo_en = 1; rx_fifo_en = 1; cyc();
        clr_mask = '1; cyc(); clr_mask = '0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        tx_dma_en = 1; rx_dma_en = 1;
        repeat (3) cyc();
        rst_n = 1; cyc();
        // R1 reset state
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_flags", tx_flags, 4'b0011);
        chk("R1 status", irq_status, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dma", {tx_dma_req, rx_dma_req}, 0);

        // R5 R6 R7 table walk
        foreach (VEC[i]) begin
            restart();
            for (int k = 0; k < VEC[i][17:12]; k++) begin
                tx_wr = 1; rx_push = 1; tx_wdata = 16'(k); rx_sdata = 16'(k);
                cyc();
            end
            tx_wr = 0; rx_push = 0;
            tx_thresh = VEC[i][11:6]; rx_thresh = VEC[i][11:6];
            #1;
            chk($sformatf("R5 tx_dma_req vec%0d", i), tx_dma_req, VEC[i][5]);
            chk($sformatf("R6 rx_dma_req vec%0d", i), rx_dma_req, VEC[i][4]);
            chk($sformatf("R7 tx_flags vec%0d", i), tx_flags, VEC[i][3:0]);
            chk($sformatf("R7 rx_flags vec%0d", i), rx_flags, VEC[i][3:0]);
            chk($sformatf("R2 count vec%0d", i), tx_count, VEC[i][17:12]);
        end

        // R2 R3: tx fill past full, order preserved, extra word dropped
        restart();
        for (int k = 0; k < 33; k++) begin
            tx_wr = 1; tx_wdata = (k == 32) ? 16'hDEAD : 16'(16'h100 + k);
            cyc();
        end
        tx_wr = 0;
        chk("R3 tx count stays full", tx_count, 32);
        chk("R3 tx overflow bit5", irq_status[5], 1);
        for (int k = 0; k < 32; k++) begin
            chk("R2 tx order", tx_sdata, 16'h100 + k);
            tx_req_word = 1; cyc(); tx_req_word = 0;
        end
        chk("R2 tx drained", tx_count, 0);

        // R4 tx starve
        clr_mask = '1; cyc(); clr_mask = '0;
        tx_req_word = 1; #1;
        chk("R4 tx starve zero word", tx_sdata, 0);
        cyc(); tx_req_word = 0;
        chk("R4 tx starve bit4", irq_status[4], 1);

        // R8 sticky, clear, set wins
        repeat (3) cyc();
        chk("R8 starve sticky", irq_status[4], 1);
        // R9 irq gating
        irq_src_en = 13'h0010; #1;
        chk("R9 irq gated by global", irq, 0);
        irq_global_en = 1; #1;
        chk("R9 irq raised", irq, 1);
        clr_mask = 13'h0010; cyc(); clr_mask = '0;
        chk("R8 starve cleared", irq_status[4], 0);
        chk("R9 irq drops after clear", irq, 0);
        clr_mask = 13'h0001; cyc(); clr_mask = '0;
        chk("R8 set wins over clear", irq_status[0], 1);
        irq_src_en = 13'h0001; #1;
        chk("R9 irq other source", irq, 1);
        irq_src_en = '0; irq_global_en = 0;

        // R12 R2 rx order and valid bit, R4 rx starve, R11 word transfer
        restart();
        clr_mask = 13'h1000; cyc(); clr_mask = '0;
        chk("R11 no transfer no bit12", irq_status[12], 0);
        rx_push = 1; rx_sdata = 16'hA001; cyc();
        rx_sdata = 16'hA002; cyc(); rx_push = 0;
        chk("R11 word transfer bit12", irq_status[12], 1);
        chk("R12 rx head valid", rx_rdata, 17'h1A001);
        rx_rd = 1; cyc();
        chk("R12 rx second word", rx_rdata, 17'h1A002);
        cyc(); rx_rd = 0;
        chk("R12 rx empty invalid", rx_rdata, 0);
        clr_mask = '1; cyc(); clr_mask = '0;
        rx_rd = 1; cyc(); rx_rd = 0;
        chk("R4 rx starve bit10", irq_status[10], 1);

        // R3 rx overflow
        for (int k = 0; k < 33; k++) begin
            rx_push = 1; rx_sdata = 16'(k); cyc();
        end
        rx_push = 0;
        chk("R3 rx count stays full", rx_count, 32);
        chk("R3 rx overflow bit11", irq_status[11], 1);

        // R10 flush and ignore while disabled
        restart();
        for (int k = 0; k < 3; k++) begin
            tx_wr = 1; tx_wdata = 16'(k); cyc();
        end
        tx_wr = 0;
        tx_fifo_en = 0; cyc();
        chk("R10 flush count", tx_count, 0);
        clr_mask = '1; cyc(); clr_mask = '0;
        tx_wr = 1; tx_req_word = 1; cyc(); tx_wr = 0; tx_req_word = 0;
        chk("R10 disabled write ignored", tx_count, 0);
        chk("R10 disabled no tx status", irq_status[5:0], 0);
        chk("R10 disabled no dma req", tx_dma_req, 0);

        summary();
    end
endmodule